// File: doc/BRIEF.md
# Replay-Lag Frequency Governor

This block picks the operating level (a frequency and voltage pair, given as an index) of a redundant core that replays the work of a primary core. The redundant core takes its branch outcomes and load values from two replay queues. The fill level of each queue shows how far the redundant core is lagging behind. A full queue means the redundant core is too slow. An almost empty queue means it runs faster than it needs to.

Once every sampling period the governor compares both fill levels with a high and a low threshold. If either queue is above the high threshold, it raises the level index by one. If neither is, but either queue is below the low threshold, it lowers the index by one. Otherwise it keeps the index. The index stays inside a configured range. A one-cycle strobe marks every change of the index, so the regulator and clock generator know when to move. While the governor is disabled, it holds the redundant core at the top of the range so that it keeps pace with the primary.

Top module: `rcore_dvfs_gov`

## Requirements
- R1: During synchronous reset (active low), `level` takes the value of `lvl_max` and `level_chg` is 0.
- R2: While `en` is high, a decision is taken on every `period`-th enabled clock edge. The count starts from zero whenever `en` is low. A `period` of 0 acts as 1.
- R3: At a decision, if `boq_fill > thr_hi` or `lvq_fill > thr_hi` (strictly greater), the level rises by one. This test wins over the lowering test.
- R4: At a decision where R3 does not apply, if `boq_fill < thr_lo` or `lvq_fill < thr_lo` (strictly less), the level falls by one.
- R5: At a decision where neither R3 nor R4 applies, the level is kept.
- R6: The level saturates: a rise at `lvl_max` or a fall at `lvl_min` leaves the level at that bound. Any decision result is clamped into [`lvl_min`, `lvl_max`].
- R7: On an enabled edge that is not a decision, the level does not change. The level moves at most one step per decision.
- R8: `level_chg` is high for exactly the cycles in which `level` shows a value that differs from its value in the previous cycle.
- R9: On every clock edge where `en` is low, `level` takes the value of `lvl_max`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Governor enable |
| boq_fill | input | OCC_W | Branch outcome queue occupancy |
| lvq_fill | input | OCC_W | Load value queue occupancy |
| thr_hi | input | OCC_W | High occupancy threshold |
| thr_lo | input | OCC_W | Low occupancy threshold |
| period | input | PER_W | Sampling period in cycles |
| lvl_min | input | LVL_W | Lowest allowed level index |
| lvl_max | input | LVL_W | Highest allowed level index |
| level | output | LVL_W | Current level index |
| level_chg | output | 1 | One-cycle strobe on a level change |

## Verification
The bench drives one queue above the high threshold while the other sits below the low threshold. A design that checks the lowering test first would step down instead of up. It drives fill levels exactly equal to each threshold, where a design that uses non-strict compares would step when it should hold. It holds the level at both bounds and pushes past them, which a design without saturation would wrap. It checks the decision spacing with periods of 0, 1 and 4, and after re-enabling. A timer off by one would move the level a cycle early or late. It also checks that the strobe appears only on real changes, including the forced jump to the maximum when the governor is disabled.

// File: rtl/dvfs_gov_pkg.sv
package dvfs_gov_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;
endpackage

// File: rtl/gov_period_timer.sv
module gov_period_timer #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;

  // last count value of a period; zero period behaves as one
  function automatic logic [PER_W-1:0] last_count(input logic [PER_W-1:0] p);
    return (p == '0) ? '0 : p - PER_W'(1);
  endfunction

  logic [PER_W-1:0] cnt_end;
  assign cnt_end = last_count(period);
  assign tick    = en && (cnt >= cnt_end);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + PER_W'(1);
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period > PER_W'(1)) |=> (!tick || period != $past(period)));

  // R2
  tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (cnt == '0));
endmodule

// File: rtl/gov_step_decide.sv
module gov_step_decide
  import dvfs_gov_pkg::*;
#(
  parameter int OCC_W = 8
) (
  input  logic [OCC_W-1:0] boq_fill,
  input  logic [OCC_W-1:0] lvq_fill,
  input  logic [OCC_W-1:0] thr_hi,
  input  logic [OCC_W-1:0] thr_lo,
  output logic             over_hi,
  output logic             under_lo,
  output step_e            step
);
  assign over_hi  = (boq_fill > thr_hi) || (lvq_fill > thr_hi);
  assign under_lo = (boq_fill < thr_lo) || (lvq_fill < thr_lo);

  always_comb begin
    if (over_hi)       step = STEP_UP;
    else if (under_lo) step = STEP_DOWN;
    else               step = STEP_HOLD;
  end
endmodule

// File: rtl/gov_level_reg.sv
module gov_level_reg
  import dvfs_gov_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  step_e            step,
  input  logic [LVL_W-1:0] lvl_min,
  input  logic [LVL_W-1:0] lvl_max,
  output logic [LVL_W-1:0] level,
  output logic             level_chg
);
  function automatic logic [LVL_W-1:0] apply_step(
    input logic [LVL_W-1:0] cur, input step_e st,
    input logic [LVL_W-1:0] mn, input logic [LVL_W-1:0] mx);
    logic [LVL_W-1:0] r;
    r = cur;
    if (st == STEP_UP && cur < mx)        r = cur + LVL_W'(1);
    else if (st == STEP_DOWN && cur > mn) r = cur - LVL_W'(1);
    if (r > mx) r = mx;
    if (r < mn) r = mn;
    return r;
  endfunction

  logic [LVL_W-1:0] lvl_nxt;

  always_comb begin
    if (!en)       lvl_nxt = lvl_max;
    else if (tick) lvl_nxt = apply_step(level, step, lvl_min, lvl_max);
    else           lvl_nxt = level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level     <= lvl_max;
      level_chg <= 1'b0;
    end else begin
      level     <= lvl_nxt;
      level_chg <= (lvl_nxt != level);
    end
  end

  // R7
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (level == $past(level)));

  // R8
  strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_chg == (level != $past(level)));

  // R9
  disabled_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (level == $past(lvl_max)));

  // R6
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && lvl_min <= lvl_max) |=>
      (level <= $past(lvl_max) && level >= $past(lvl_min)));
endmodule

// File: rtl/rcore_dvfs_gov.sv
module rcore_dvfs_gov
  import dvfs_gov_pkg::*;
#(
  parameter int OCC_W = 8,
  parameter int PER_W = 12,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [OCC_W-1:0] boq_fill,
  input  logic [OCC_W-1:0] lvq_fill,
  input  logic [OCC_W-1:0] thr_hi,
  input  logic [OCC_W-1:0] thr_lo,
  input  logic [PER_W-1:0] period,
  input  logic [LVL_W-1:0] lvl_min,
  input  logic [LVL_W-1:0] lvl_max,
  output logic [LVL_W-1:0] level,
  output logic             level_chg
);
  logic  tick;
  logic  over_hi;
  logic  under_lo;
  step_e step;

  gov_period_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .tick(tick));

  gov_step_decide #(.OCC_W(OCC_W)) u_decide (
    .boq_fill(boq_fill), .lvq_fill(lvq_fill), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .over_hi(over_hi), .under_lo(under_lo), .step(step));

  gov_level_reg #(.LVL_W(LVL_W)) u_level (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .step(step),
    .lvl_min(lvl_min), .lvl_max(lvl_max), .level(level), .level_chg(level_chg));

  // R3
  up_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && over_hi && level < lvl_max && level >= lvl_min) |=>
      (level == $past(level) + LVL_W'(1)));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !over_hi && under_lo && level > lvl_min && level <= lvl_max) |=>
      (level == $past(level) - LVL_W'(1)));
endmodule

// File: tb/tb_rcore_dvfs_gov.sv
module tb_rcore_dvfs_gov;
  localparam int CLK_PERIOD = 10;
  localparam int OCC_W = 8;
  localparam int PER_W = 12;
  localparam int LVL_W = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en;
  logic [OCC_W-1:0] boq_fill, lvq_fill, thr_hi, thr_lo;
  logic [PER_W-1:0] period;
  logic [LVL_W-1:0] lvl_min, lvl_max;
  logic [LVL_W-1:0] level;
  logic             level_chg;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";

  rcore_dvfs_gov #(.OCC_W(OCC_W), .PER_W(PER_W), .LVL_W(LVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .boq_fill(boq_fill), .lvq_fill(lvq_fill),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .period(period), .lvl_min(lvl_min),
    .lvl_max(lvl_max), .level(level), .level_chg(level_chg));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference behaviour restated with plain integers
  function automatic int want_level(int cur, int b, int l, int hi, int lo, int mn, int mx);
    int w;
    if (b > hi || l > hi)      w = cur + 1;
    else if (b < lo || l < lo) w = cur - 1;
    else                       w = cur;
    if (w > mx) w = mx;
    if (w < mn) w = mn;
    return w;
  endfunction

  function automatic int period_len(int p);
    return (p < 1) ? 1 : p;
  endfunction

  int m_cnt = 0;
  int m_lvl = 0;
  bit m_chg = 0;

  always @(posedge clk) begin
    int nl;
    if (!rst_n) begin
      m_cnt <= 0; m_lvl <= int'(lvl_max); m_chg <= 0;
    end else if (!en) begin
      m_cnt <= 0; m_chg <= (int'(lvl_max) != m_lvl); m_lvl <= int'(lvl_max);
    end else begin
      if (m_cnt + 1 >= period_len(int'(period))) begin
        nl = want_level(m_lvl, int'(boq_fill), int'(lvq_fill), int'(thr_hi),
                        int'(thr_lo), int'(lvl_min), int'(lvl_max));
        m_cnt <= 0;
      end else begin
        nl = m_lvl;
        m_cnt <= m_cnt + 1;
      end
      m_chg <= (nl != m_lvl);
      m_lvl <= nl;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_model();
    check(cur_req, int'(level), m_lvl, "level vs model");
    check("R8", int'(level_chg), int'(m_chg), "strobe vs model");
  endtask

  task automatic cyc();
    @(negedge clk);
    check_model();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog R2: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; en = 0; boq_fill = 0; lvq_fill = 0; thr_hi = 20; thr_lo = 5;
    period = 3; lvl_min = 1; lvl_max = 6;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", int'(level), 6, "reset level");
    check("R1", int'(level_chg), 0, "reset strobe");
    rst_n = 1;
    en = 1;

    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cur_req = (i % 2 == 0) ? "R3" : "R5";
      check_model();
      boq_fill = OCC_W'($urandom_range(0, 40));
      lvq_fill = OCC_W'($urandom_range(0, 40));
      if ($urandom_range(0, 7) == 0) boq_fill = thr_hi;
      if ($urandom_range(0, 7) == 0) lvq_fill = thr_lo;
      if ($urandom_range(0, 60) == 0) en = ~en;
      if ($urandom_range(0, 100) == 0) period = PER_W'($urandom_range(0, 5));
      if ($urandom_range(0, 150) == 0) begin
        thr_lo = OCC_W'($urandom_range(0, 15));
        thr_hi = thr_lo + OCC_W'($urandom_range(0, 20));
      end
      if ($urandom_range(0, 200) == 0) begin
        lvl_min = LVL_W'($urandom_range(0, 3));
        lvl_max = lvl_min + LVL_W'($urandom_range(0, 4));
      end
    end

    // directed: disabled forces maximum (R9)
    cur_req = "R9";
    en = 0; lvl_min = 1; lvl_max = 6; thr_hi = 20; thr_lo = 5; period = 1;
    boq_fill = 10; lvq_fill = 10;
    cyc(); cyc();
    check("R9", int'(level), 6, "disabled level");

    // R3 priority and R6 saturation at max
    en = 1; cur_req = "R3";
    boq_fill = 30; lvq_fill = 0;
    cyc();
    check("R6", int'(level), 6, "up saturates at max");
    check("R8", int'(level_chg), 0, "no strobe at saturation");

    // R5 hold at exact thresholds
    cur_req = "R5";
    boq_fill = 20; lvq_fill = 5;
    cyc();
    check("R5", int'(level), 6, "hold at thresholds");

    // R4 stepping down to min
    cur_req = "R4";
    boq_fill = 10; lvq_fill = 2;
    for (int k = 5; k >= 1; k--) begin
      cyc();
      check("R4", int'(level), k, "down step");
      check("R8", int'(level_chg), 1, "strobe on step");
    end
    cyc();
    check("R6", int'(level), 1, "down saturates at min");
    check("R8", int'(level_chg), 0, "no strobe at min");

    // R2/R7: period of 4, rise only on the 4th enabled edge
    cur_req = "R7";
    period = 4; boq_fill = 30; lvq_fill = 10;
    cyc(); check("R7", int'(level), 1, "no move edge 1");
    cyc(); check("R7", int'(level), 1, "no move edge 2");
    cyc(); check("R7", int'(level), 1, "no move edge 3");
    cyc(); check("R2", int'(level), 2, "decision on edge 4");

    // R2: period 0 behaves as 1
    cur_req = "R2";
    period = 0;
    cyc(); check("R2", int'(level), 3, "period zero decides each edge");

    // R9 again with strobe on forced jump
    en = 0; cur_req = "R9";
    cyc();
    check("R9", int'(level), 6, "jump to max when disabled");
    check("R8", int'(level_chg), 1, "strobe on forced jump");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule